// File: doc/BRIEF.md
# Answer-to-Reset Parser

This block sits behind the character receiver of a smart-card interface and interprets the byte stream that a card sends after it is reset. The first byte sets the bit convention. The block then follows the chain of interface characters, where each announcing byte says which of the next group's four optional bytes will follow. It skips the historical bytes and, when the card offers any protocol other than T=0, checks the closing check byte. The parameters found are held on output registers for the link layer.

A malformed answer still ends with `done`, together with a non-compliant flag, and the outputs are left at their defaults. An external inter-byte gap timeout input stops a parse that has stalled. Mapping the F and D indices to clock counts and negotiating a protocol are handled elsewhere.

Top module: `atr_parser`

## Requirements
- R1: The initial byte is matched on its raw value. 0x3B selects direct convention: later bytes are used as received and `inverse` is 0. 0x3F selects inverse convention: each later byte is decoded as the bitwise complement of its bit-reversed raw value and `inverse` is 1.
- R2: An initial byte other than 0x3B or 0x3F raises `done` and `noncompliant` on the next clock and leaves every parameter at its default.
- R3: In the format byte, bits 4, 5, 6 and 7 announce TA1, TB1, TC1 and TD1 respectively, and bits 3:0 give the number of historical bytes. In each TD byte, bits 7:4 announce the next group in the same way. Bytes within a group arrive in the order TA, TB, TC, TD.
- R4: TA1 sets `fi_idx` from bits 7:4 and `di_idx` from bits 3:0. TC1 sets `guard_n`. When these bytes are absent the values are fi_idx=1, di_idx=1 and guard_n=0. TB1 has no effect on any output.
- R5: Each TD byte sets bit T of `proto_mask`, where T is its bits 3:0. `proto_dflt` is the T of TD1. With no TD1, proto_mask=0x0001 and proto_dflt=0.
- R6: TC2 sets `wi`, whose default is 10.
- R7: The first group at level three or deeper that is announced by a TD with T=1 supplies three values. Its TA sets `ifsc` (default 32); a TA of 0x00 or 0xFF makes the answer non-compliant. Its TB sets `bwi` from bits 7:4 (default 4) and `cwi` from bits 3:0 (default 13). Bit 0 of its TC sets `crc_sel` (default 0).
- R8: A check byte follows the historical bytes only if some TD announced a T other than 0. If the XOR of every byte from the format byte through the check byte is not zero, the answer is non-compliant.
- R9: If a 33rd byte arrives after the initial byte (MAX_LEN=32), parsing ends on that byte as non-compliant.
- R10: A non-compliant completion sets `done` and `noncompliant` and sets every parameter output to its default.
- R11: `gap_timeout` while a parse is in progress raises `timeout_err` on the next clock, keeps `done` low and returns the block to waiting for an initial byte. While idle, `gap_timeout` is ignored.
- R12: The results and `done` are updated on the clock edge that takes the final byte. They hold until the next initial byte arrives, which clears `done`, `noncompliant` and `timeout_err` and returns the parameters to their defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_vld | input | 1 | One-cycle strobe: a received byte is present |
| rx_byte | input | 8 | Received byte, raw as seen on the line |
| gap_timeout | input | 1 | Inter-byte gap expired |
| done | output | 1 | Parse complete |
| noncompliant | output | 1 | Answer was malformed; parameters left at defaults |
| timeout_err | output | 1 | Parse aborted by gap timeout |
| inverse | output | 1 | Inverse convention in use |
| fi_idx | output | 4 | Clock-rate conversion index |
| di_idx | output | 4 | Bit-rate adjustment index |
| guard_n | output | 8 | Extra guard time |
| wi | output | 8 | Work waiting integer |
| ifsc | output | 8 | Card information field size |
| bwi | output | 4 | Block waiting integer |
| cwi | output | 4 | Character waiting integer |
| crc_sel | output | 1 | 1 selects CRC, 0 selects LRC |
| proto_mask | output | 16 | One bit per offered protocol number |
| proto_dflt | output | 4 | Default protocol number |

## Verification
If the presence mask or the level counter is wrong, the block miscounts the structure of the answer. It then ends one or more bytes early or late, and the fault shows up at the end of that same answer: `done` rises at the wrong byte, the check byte is read as data, or a good answer is flagged non-compliant. A wrong historical-byte count or a wrong check-byte decision shows up the same way, no later than the last byte of the answer. An error in decoding the convention damages every later byte, so an inverse-convention answer whose content matches a direct one must give identical parameters.

// File: rtl/atr_pkg.sv
// Package: shared types, defaults and the next-step rule of the parser.
// Assumes bytes are 8 bits wide and protocol numbers are 4 bits wide.
package atr_pkg;

    localparam logic [7:0] TS_DIRECT  = 8'h3B;
    localparam logic [7:0] TS_INVERSE = 8'h3F;

    localparam logic [3:0] DEF_FI   = 4'd1;
    localparam logic [3:0] DEF_DI   = 4'd1;
    localparam logic [7:0] DEF_N    = 8'd0;
    localparam logic [7:0] DEF_WI   = 8'd10;
    localparam logic [7:0] DEF_IFSC = 8'd32;
    localparam logic [3:0] DEF_BWI  = 4'd4;
    localparam logic [3:0] DEF_CWI  = 4'd13;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FMT,
        ST_IFACE,
        ST_HIST,
        ST_CHK
    } walk_st_e;

    typedef struct packed {
        logic [3:0]  fi;
        logic [3:0]  di;
        logic [7:0]  n;
        logic [7:0]  wi;
        logic [7:0]  ifsc;
        logic [3:0]  bwi;
        logic [3:0]  cwi;
        logic        crc;
        logic [15:0] mask;
        logic [3:0]  dproto;
    } params_t;

    typedef struct packed {
        logic ta1;
        logic tc1;
        logic td1;
        logic td;
        logic tc2;
        logic ta3;
        logic tb3;
        logic tc3;
    } cap_t;

    // Parameter set that is in force when nothing was announced.
    function automatic params_t prm_default();
        params_t p;
        p.fi     = DEF_FI;
        p.di     = DEF_DI;
        p.n      = DEF_N;
        p.wi     = DEF_WI;
        p.ifsc   = DEF_IFSC;
        p.bwi    = DEF_BWI;
        p.cwi    = DEF_CWI;
        p.crc    = 1'b0;
        p.mask   = 16'h0001;
        p.dproto = 4'd0;
        return p;
    endfunction

    // Chooses what is expected next: group bytes, history, check byte or the end.
    function automatic walk_st_e pick_next(logic [3:0] pend, logic [3:0] k, logic need);
        if (pend != 4'd0)   return ST_IFACE;
        else if (k != 4'd0) return ST_HIST;
        else if (need)      return ST_CHK;
        else                return ST_IDLE;
    endfunction

endpackage

// File: rtl/atr_conv.sv
// Convention decoder: classifies the initial byte and turns later raw bytes
// into logical values. Assumes the walker reports when it waits for an initial byte.
module atr_conv #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         idle,
    input  logic         byte_vld,
    input  logic [W-1:0] byte_raw,
    output logic         ts_ok,
    output logic         inverse,
    output logic [W-1:0] byte_dec
);
    import atr_pkg::*;

    logic         ts_inv;
    logic [W-1:0] rev;

    // Classify the raw initial byte.
    always_comb begin
        ts_inv = (byte_raw == TS_INVERSE);
        ts_ok  = (byte_raw == TS_DIRECT) || ts_inv;
    end

    // Reverse the bit order for the inverse convention.
    for (genvar i = 0; i < W; i++) begin : g_rev
        assign rev[i] = byte_raw[W-1-i];
    end

    // Latch the convention on every initial byte.
    always_ff @(posedge clk) begin
        if (!rst_n)                inverse <= 1'b0;
        else if (idle && byte_vld) inverse <= ts_inv;
    end

    // Decode later bytes.
    always_comb byte_dec = inverse ? ~rev : byte_raw;

    // R1
    inv_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && byte_vld && byte_raw == TS_INVERSE) |=> inverse);
    // R1
    dir_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && byte_vld && byte_raw == TS_DIRECT) |=> !inverse);

endmodule

// File: rtl/atr_walker.sv
// Structure walker: follows the presence nibbles, the historical count and the
// check byte, and emits capture strobes plus the status flags.
// Assumes at most one byte strobe per cycle; a timeout wins over a byte.
module atr_walker #(
    parameter int MAX_LEN = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_vld,
    input  logic             gap_timeout,
    input  logic             ts_ok,
    input  logic [7:0]       b,
    output logic             idle,
    output logic             start,
    output logic             finish,
    output logic             finish_bad,
    output atr_pkg::cap_t    cap,
    output logic             done,
    output logic             noncompliant,
    output logic             timeout_err
);
    import atr_pkg::*;

    localparam int CNT_W = $clog2(MAX_LEN + 2);

    walk_st_e   st, nxt_st;
    logic [3:0] pend, pend_n, cur, k, k_n, t_prev;
    logic [1:0] level;
    logic       need, need_n, t1_done, ifsc_bad, ifsc_bad_n;
    logic [7:0] xacc;
    logic [CNT_W-1:0] cnt;
    logic       busy, take, in_t1, too_long, tck_bad;
    logic       is_ta, is_tb, is_tc, is_td;

    // Work out which byte this is, what it captures and what comes next.
    always_comb begin
        cur      = pend & (~pend + 4'd1);
        is_ta    = cur[0];
        is_tb    = cur[1];
        is_tc    = cur[2];
        is_td    = cur[3];
        busy     = (st != ST_IDLE);
        take     = busy && byte_vld && !gap_timeout;
        in_t1    = (level == 2'd3) && (t_prev == 4'd1) && !t1_done;
        too_long = (cnt == CNT_W'(MAX_LEN));
        cap      = '0;
        pend_n   = pend;
        k_n      = k;
        need_n   = need;
        nxt_st   = st;
        case (st)
            ST_FMT: begin
                pend_n = b[7:4];
                k_n    = b[3:0];
                need_n = 1'b0;
                nxt_st = pick_next(pend_n, k_n, 1'b0);
            end
            ST_IFACE: begin
                cap.ta1 = take && is_ta && level == 2'd1;
                cap.tc1 = take && is_tc && level == 2'd1;
                cap.td1 = take && is_td && level == 2'd1;
                cap.td  = take && is_td;
                cap.tc2 = take && is_tc && level == 2'd2;
                cap.ta3 = take && is_ta && in_t1;
                cap.tb3 = take && is_tb && in_t1;
                cap.tc3 = take && is_tc && in_t1;
                pend_n  = is_td ? b[7:4] : (pend & ~cur);
                need_n  = need | (is_td && b[3:0] != 4'd0);
                nxt_st  = pick_next(pend_n, k, need_n);
            end
            ST_HIST: begin
                k_n    = k - 4'd1;
                nxt_st = pick_next(4'd0, k_n, need);
            end
            ST_CHK:  nxt_st = ST_IDLE;
            default: nxt_st = ST_IDLE;
        endcase
        tck_bad    = (st == ST_CHK) && ((xacc ^ b) != 8'd0);
        ifsc_bad_n = ifsc_bad | (cap.ta3 && (b == 8'h00 || b == 8'hFF));
        finish     = take && (nxt_st == ST_IDLE || too_long);
        finish_bad = too_long || tck_bad || ifsc_bad_n;
        idle       = !busy;
        start      = !busy && byte_vld;
    end

    // Sequence state, working registers and status flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE;  pend <= '0;  k <= '0;  need <= 1'b0;
            level <= 2'd1;  t_prev <= '0;  t1_done <= 1'b0;  ifsc_bad <= 1'b0;
            xacc <= '0;  cnt <= '0;
            done <= 1'b0;  noncompliant <= 1'b0;  timeout_err <= 1'b0;
        end else if (!busy) begin
            if (byte_vld) begin
                pend <= '0;  k <= '0;  need <= 1'b0;  level <= 2'd1;
                t_prev <= '0;  t1_done <= 1'b0;  ifsc_bad <= 1'b0;
                xacc <= '0;  cnt <= '0;
                done         <= !ts_ok;
                noncompliant <= !ts_ok;
                timeout_err  <= 1'b0;
                st           <= ts_ok ? ST_FMT : ST_IDLE;
            end
        end else if (gap_timeout) begin
            st          <= ST_IDLE;
            timeout_err <= 1'b1;
        end else if (byte_vld) begin
            cnt      <= cnt + CNT_W'(1);
            xacc     <= xacc ^ b;
            pend     <= pend_n;
            k        <= k_n;
            need     <= need_n;
            ifsc_bad <= ifsc_bad_n;
            if (st == ST_IFACE && is_td) begin
                level  <= (level == 2'd3) ? 2'd3 : level + 2'd1;
                t_prev <= b[3:0];
                if (in_t1) t1_done <= 1'b1;
            end
            if (finish) begin
                st           <= ST_IDLE;
                done         <= 1'b1;
                noncompliant <= finish_bad;
            end else begin
                st <= nxt_st;
            end
        end
    end

    // R2
    bad_ts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && byte_vld && !ts_ok) |=> (done && noncompliant));
    // R11
    abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && gap_timeout) |=> (timeout_err && !done && idle));
    // R11
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && timeout_err));
    // R9
    len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(MAX_LEN + 1));
    // R12
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !byte_vld) |=> done);

endmodule

// File: rtl/atr_params.sv
// Parameter store: gathers captured values in a shadow set while parsing and
// copies them to the outputs at completion, or defaults when non-compliant.
module atr_params (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              finish,
    input  logic              finish_bad,
    input  atr_pkg::cap_t     cap,
    input  logic [7:0]        b,
    output atr_pkg::params_t  prm
);
    import atr_pkg::*;

    params_t shd, shd_nxt, good;

    // Apply this cycle's captures to the shadow set.
    always_comb begin
        shd_nxt = shd;
        if (cap.ta1) {shd_nxt.fi, shd_nxt.di} = b;
        if (cap.tc1) shd_nxt.n = b;
        if (cap.td1) shd_nxt.dproto = b[3:0];
        if (cap.td)  shd_nxt.mask[b[3:0]] = 1'b1;
        if (cap.tc2) shd_nxt.wi = b;
        if (cap.ta3) shd_nxt.ifsc = b;
        if (cap.tb3) {shd_nxt.bwi, shd_nxt.cwi} = b;
        if (cap.tc3) shd_nxt.crc = b[0];
        good = shd_nxt;
        if (shd_nxt.mask == 16'd0) good.mask = 16'h0001;
    end

    // Shadow and committed registers.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            shd      <= prm_default();
            shd.mask <= 16'd0;
            prm      <= prm_default();
        end else begin
            shd <= shd_nxt;
            if (finish) prm <= finish_bad ? prm_default() : good;
        end
    end

    // R10
    nc_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && finish_bad && !start) |=> (prm == prm_default()));
    // R5
    mask_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prm.mask != 16'd0);
    // R12
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!finish && !start) |=> $stable(prm));

endmodule

// File: rtl/atr_parser.sv
// Top: answer-to-reset parser. Connects the convention decoder, the
// structure walker and the parameter store. Synchronous active-low reset.
module atr_parser #(
    parameter int MAX_LEN = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_vld,
    input  logic [7:0]  rx_byte,
    input  logic        gap_timeout,
    output logic        done,
    output logic        noncompliant,
    output logic        timeout_err,
    output logic        inverse,
    output logic [3:0]  fi_idx,
    output logic [3:0]  di_idx,
    output logic [7:0]  guard_n,
    output logic [7:0]  wi,
    output logic [7:0]  ifsc,
    output logic [3:0]  bwi,
    output logic [3:0]  cwi,
    output logic        crc_sel,
    output logic [15:0] proto_mask,
    output logic [3:0]  proto_dflt
);
    import atr_pkg::*;

    logic       idle, ts_ok, start, finish, finish_bad;
    logic [7:0] b;
    cap_t       cap;
    params_t    prm;

    atr_conv #(.W(8)) u_conv (
        .clk(clk), .rst_n(rst_n), .idle(idle), .byte_vld(rx_vld),
        .byte_raw(rx_byte), .ts_ok(ts_ok), .inverse(inverse), .byte_dec(b)
    );

    atr_walker #(.MAX_LEN(MAX_LEN)) u_walk (
        .clk(clk), .rst_n(rst_n), .byte_vld(rx_vld), .gap_timeout(gap_timeout),
        .ts_ok(ts_ok), .b(b), .idle(idle), .start(start), .finish(finish),
        .finish_bad(finish_bad), .cap(cap), .done(done),
        .noncompliant(noncompliant), .timeout_err(timeout_err)
    );

    atr_params u_prm (
        .clk(clk), .rst_n(rst_n), .start(start), .finish(finish),
        .finish_bad(finish_bad), .cap(cap), .b(b), .prm(prm)
    );

    // Drive the parameter ports from the committed set.
    always_comb begin
        fi_idx     = prm.fi;
        di_idx     = prm.di;
        guard_n    = prm.n;
        wi         = prm.wi;
        ifsc       = prm.ifsc;
        bwi        = prm.bwi;
        cwi        = prm.cwi;
        crc_sel    = prm.crc;
        proto_mask = prm.mask;
        proto_dflt = prm.dproto;
    end

endmodule

// File: tb/test_atr_parser.sv
// Scoreboard bench: the driver queues the expected result of each answer and
// sends its bytes; the monitor compares each completion or abort it sees.
module test_atr_parser;

    typedef struct packed {
        logic        done, nc, terr, inv;
        logic [3:0]  fi, di;
        logic [7:0]  n, wi, ifsc;
        logic [3:0]  bwi, cwi;
        logic        crc;
        logic [15:0] mask;
        logic [3:0]  dp;
    } exp_t;

    logic clk = 1'b0, rst_n = 1'b0, rx_vld = 1'b0, gap_timeout = 1'b0;
    logic [7:0] rx_byte = 8'd0;
    logic done, noncompliant, timeout_err, inverse, crc_sel;
    logic [3:0] fi_idx, di_idx, bwi, cwi, proto_dflt;
    logic [7:0] guard_n, wi, ifsc;
    logic [15:0] proto_mask;

    int checks = 0, fails = 0;
    bit finished = 0;
    exp_t exp_q[$];
    logic [7:0] seq[$];
    logic prev_done = 1'b0, prev_terr = 1'b0;

    always #2.5 clk = ~clk;

    atr_parser i_atr_parser (
        .clk(clk), .rst_n(rst_n), .rx_vld(rx_vld), .rx_byte(rx_byte),
        .gap_timeout(gap_timeout), .done(done), .noncompliant(noncompliant),
        .timeout_err(timeout_err), .inverse(inverse), .fi_idx(fi_idx),
        .di_idx(di_idx), .guard_n(guard_n), .wi(wi), .ifsc(ifsc), .bwi(bwi),
        .cwi(cwi), .crc_sel(crc_sel), .proto_mask(proto_mask), .proto_dflt(proto_dflt)
    );

    task automatic chk(string req, string fld, int act, int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, fld, act, expv);
        end
    endtask

    function automatic exp_t dflt();
        exp_t e;
        e = '0;
        e.fi = 4'd1; e.di = 4'd1; e.wi = 8'd10; e.ifsc = 8'd32;
        e.bwi = 4'd4; e.cwi = 4'd13; e.mask = 16'h0001;
        return e;
    endfunction

    task automatic compare(exp_t e);
        chk("R12", "done", done, e.done);
        chk("R10", "noncompliant", noncompliant, e.nc);
        chk("R11", "timeout_err", timeout_err, e.terr);
        chk("R1", "inverse", inverse, e.inv);
        chk("R4", "fi_idx", fi_idx, e.fi);
        chk("R4", "di_idx", di_idx, e.di);
        chk("R4", "guard_n", guard_n, e.n);
        chk("R6", "wi", wi, e.wi);
        chk("R7", "ifsc", ifsc, e.ifsc);
        chk("R7", "bwi", bwi, e.bwi);
        chk("R7", "cwi", cwi, e.cwi);
        chk("R7", "crc_sel", crc_sel, e.crc);
        chk("R5", "proto_mask", proto_mask, e.mask);
        chk("R5", "proto_dflt", proto_dflt, e.dp);
    endtask

    // Monitor: one expected item per completion or abort.
    always @(negedge clk) begin
        if (rst_n && ((done && !prev_done) || (timeout_err && !prev_terr))) begin
            if (exp_q.size() == 0) chk("R12", "unexpected_result", 1, 0);
            else compare(exp_q.pop_front());
        end
        prev_done <= done;
        prev_terr <= timeout_err;
    end

    function automatic logic [7:0] enc_inv(logic [7:0] v);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = ~v[7-i];
        return r;
    endfunction

    task automatic put(logic [7:0] raw);
        @(negedge clk); rx_vld = 1'b1; rx_byte = raw;
        @(negedge clk); rx_vld = 1'b0;
    endtask

    // Sends seq: entry 0 is the raw initial byte, the rest are logical values.
    task automatic send(bit inv, bit add_tck, bit tck_flip, exp_t e);
        logic [7:0] x;
        x = 8'd0;
        for (int i = 1; i < seq.size(); i++) x ^= seq[i];
        if (add_tck) seq.push_back(x ^ (tck_flip ? 8'h01 : 8'h00));
        exp_q.push_back(e);
        put(seq[0]);
        for (int i = 1; i < seq.size(); i++) put(inv ? enc_inv(seq[i]) : seq[i]);
        repeat (3) @(negedge clk);
        seq.delete();
    endtask

    task automatic full_t1(logic [7:0] ta3);
        seq = '{8'h00, 8'h95, 8'h13, 8'h81, 8'h71, ta3, 8'h52, 8'h01,
                8'h41, 8'h42, 8'h43, 8'h44, 8'h45};
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        exp_t e;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        compare(dflt());

        // R3 minimal answer, format byte only
        seq = '{8'h3B, 8'h00}; e = dflt(); e.done = 1; send(0, 0, 0, e);

        // R4 R5 R7 R8 full T=1 answer, direct convention
        full_t1(8'h80); seq[0] = 8'h3B;
        e = dflt(); e.done = 1; e.di = 4'd3; e.ifsc = 8'h80; e.bwi = 4'd5;
        e.cwi = 4'd2; e.crc = 1; e.mask = 16'h0002; e.dp = 4'd1;
        send(0, 1, 0, e);

        // R1 same content, inverse convention
        full_t1(8'h80); seq[0] = 8'h3F; e.inv = 1; send(1, 1, 0, e);

        // R4 TC1 guard with TB1 ignored, two historical bytes, no check byte
        seq = '{8'h3B, 8'h62, 8'h05, 8'h07, 8'h11, 8'h22};
        e = dflt(); e.done = 1; e.n = 8'd7; send(0, 0, 0, e);

        // R6 TC2 work waiting integer with T=0 only
        seq = '{8'h3B, 8'h80, 8'h40, 8'h14};
        e = dflt(); e.done = 1; e.wi = 8'd20; send(0, 0, 0, e);

        // R5 R8 T=0 and T=1 offered, check byte present
        seq = '{8'h3B, 8'h80, 8'h80, 8'h01};
        e = dflt(); e.done = 1; e.mask = 16'h0003; send(0, 1, 0, e);

        // R8 R10 bad check byte
        seq = '{8'h3B, 8'h80, 8'h80, 8'h01};
        e = dflt(); e.done = 1; e.nc = 1; send(0, 1, 1, e);

        // R7 invalid information field size
        full_t1(8'hFF); seq[0] = 8'h3B;
        e = dflt(); e.done = 1; e.nc = 1; send(0, 1, 0, e);

        // R11 gap timeout mid-parse
        e = dflt(); e.terr = 1; exp_q.push_back(e);
        put(8'h3B); put(8'h0F); put(8'h41); put(8'h42);
        @(negedge clk); gap_timeout = 1'b1;
        @(negedge clk); gap_timeout = 1'b0;
        repeat (3) @(negedge clk);
        // R11 timeout while idle has no effect
        @(negedge clk); gap_timeout = 1'b1;
        @(negedge clk); gap_timeout = 1'b0;
        @(negedge clk);
        chk("R11", "idle_timeout_done", done, 0);
        chk("R11", "idle_timeout_err", timeout_err, 1);

        // R2 invalid initial byte
        seq = '{8'h55}; e = dflt(); e.done = 1; e.nc = 1; send(0, 0, 0, e);

        // R9 too long: format byte plus 32 TD bytes
        seq = '{8'h3B, 8'h8F};
        for (int i = 0; i < 32; i++) seq.push_back(8'h80);
        e = dflt(); e.done = 1; e.nc = 1; send(0, 0, 0, e);

        // R12 a good answer after errors
        seq = '{8'h3B, 8'h10, 8'h96};
        e = dflt(); e.done = 1; e.fi = 4'd9; e.di = 4'd6; send(0, 0, 0, e);

        repeat (5) @(negedge clk);
        chk("R12", "queue_empty", exp_q.size(), 0);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule